// File: doc/BRIEF.md
# Off-Board Access Bus Requester

This block sits between a board's processor and two targets: the local memory on the board, and a shared bus that links several processor boards. Each processor access goes through an address check. An address inside a configured window goes out over the shared bus. Every other address goes straight to local memory.

For a remote access, the block first raises one bus request line and waits for the arbiter's daisy-chained grant. It then claims the bus, presents the address and the write data, and strobes the address. The remote board decides whether to accept the access. It can answer with a transfer acknowledge, which carries read data, or with a bus error. A local timeout stands in for a board that never answers. The result goes back to the processor, and the block then frees the bus. While the block is idle, it passes the incoming grant down the chain unchanged.

All bus control lines are active-low. Reset is synchronous and active-high.

Top module: `obr_requester`

## Requirements
- R1: An accepted access whose address lies in [WIN_BASE, WIN_LAST] (default 0x800000 to 0xBFFFFF) is off-board. Any other address raises `loc_en` in the same cycle as `cpu_req`, with `loc_addr`, `loc_we` and `loc_wdata` copied from the processor inputs, and no bus request is made.
- R2: One cycle after `loc_en`, `cpu_done` is 1, `cpu_err` is 0, and `cpu_rdata` equals `loc_rdata`.
- R3: In the cycle after an off-board access is accepted, `bus_br_n[REQ_LEVEL]` (default level 3) goes low while the other three levels stay high. It stays low until `bus_bg_in_n` is seen low, counting from the second cycle of the request, and goes high in the cycle after that.
- R4: `bus_bbsy_n` is low from the cycle after the grant is taken through the last cycle of the acknowledge wait. It is high in the completion cycle.
- R5: For exactly one cycle after the grant, `bus_addr`, `bus_write_n` (low for a write) and `bus_wdata` (the write data, or 0 on a read) are driven while `bus_as_n` is still high. `bus_as_n` then goes low with those values held. When no transfer is in progress, the address and data outputs are 0 and the strobes are high.
- R6: If `bus_dtack_n` is low while `bus_as_n` is low, then in the next cycle `bus_as_n` is high, `cpu_done` is 1, `cpu_err` is 0, and `cpu_rdata` is the `bus_rdata` value seen with the acknowledge.
- R7: If `bus_berr_n` is low while `bus_as_n` is low, then in the next cycle `cpu_done` and `cpu_err` are 1 and `cpu_rdata` is 0. When `bus_berr_n` and `bus_dtack_n` arrive together, the error wins.
- R8: If neither response arrives within TIMEOUT cycles of strobe (default 16), the access ends as an error, as in R7. An acknowledge in the TIMEOUT-th strobe cycle still counts as a success.
- R9: While idle, `bus_bg_out_n` follows `bus_bg_in_n`. In every other state it is held high.
- R10: `cpu_ready` is 1 only when idle. A `cpu_req` that arrives while `cpu_ready` is 0 is dropped: it raises no `loc_en`, makes no request, and adds no completion.
- R11: After reset, `cpu_ready` is 1. All bus control outputs are high, `bus_addr` and `bus_wdata` are 0, and `cpu_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | AW | Access address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Block can take an access |
| cpu_done | output | 1 | Completion pulse |
| cpu_err | output | 1 | Completion was an error |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| loc_en | output | 1 | Local memory access strobe |
| loc_we | output | 1 | Local memory write |
| loc_addr | output | AW | Local memory address |
| loc_wdata | output | DW | Local memory write data |
| loc_rdata | input | DW | Local memory read data, one cycle after loc_en |
| bus_br_n | output | 4 | Bus request lines, one per level |
| bus_bg_in_n | input | 1 | Grant arriving down the daisy chain |
| bus_bg_out_n | output | 1 | Grant passed on down the chain |
| bus_bbsy_n | output | 1 | Bus busy |
| bus_as_n | output | 1 | Address strobe |
| bus_write_n | output | 1 | Low for a write cycle |
| bus_addr | output | AW | Remote address |
| bus_wdata | output | DW | Remote write data |
| bus_rdata | input | DW | Remote read data |
| bus_dtack_n | input | 1 | Transfer acknowledge |
| bus_berr_n | input | 1 | Bus error |

## Verification
The bench sends local accesses at the two addresses just outside each window edge and checks that they never touch the bus. It sends remote reads and writes at the two window edges with grant delays of zero and several cycles, which separates the request-drop timing from the grant latency. On the remote side it plays acknowledge, bus error, both at once, and silence. It also places acknowledges in the last and the first-too-late strobe cycle, which splits the response priority from the timeout boundary. Stray requests arrive while a transfer is busy and during completion, and foreign grants arrive both while idle and while the block is requesting, so the ignore rule and the daisy-chain pass-through are each observed at the ports.

// File: rtl/obr_pkg.sv
package obr_pkg;

    localparam int unsigned NUM_LEVELS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_GRANT,
        ST_ADDRESS,
        ST_WAIT_ACK,
        ST_RELEASE
    } obr_state_e;

    typedef enum logic [1:0] {
        RES_PENDING,
        RES_OK,
        RES_FAIL
    } obr_result_e;

    // Response priority during the strobe: error, then acknowledge, then timeout.
    function automatic obr_result_e obr_resolve(input logic berr_n,
                                                input logic dtack_n,
                                                input logic expired);
        if (!berr_n)       return RES_FAIL;
        else if (!dtack_n) return RES_OK;
        else if (expired)  return RES_FAIL;
        else               return RES_PENDING;
    endfunction

endpackage

// File: rtl/obr_decode.sv
module obr_decode #(
    parameter int unsigned      AW       = 24,
    parameter logic [AW-1:0]    WIN_BASE = 'h800000,
    parameter logic [AW-1:0]    WIN_LAST = 'hBFFFFF
) (
    input  logic [AW-1:0] addr,
    output logic          remote
);
    always_comb begin
        remote = (addr >= WIN_BASE) && (addr <= WIN_LAST);
    end
endmodule

// File: rtl/obr_timer.sv
module obr_timer #(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(TIMEOUT - 1));
endmodule

// File: rtl/obr_seq.sv
module obr_seq
    import obr_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter int unsigned DW        = 16,
    parameter int unsigned REQ_LEVEL = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  cpu_we,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [DW-1:0]         cpu_wdata,
    input  logic                  bus_bg_in_n,
    input  logic [DW-1:0]         bus_rdata,
    input  logic                  bus_dtack_n,
    input  logic                  bus_berr_n,
    input  logic                  expired,
    output obr_state_e            state,
    output logic [NUM_LEVELS-1:0] bus_br_n,
    output logic                  bus_bbsy_n,
    output logic                  bus_as_n,
    output logic                  bus_write_n,
    output logic [AW-1:0]         bus_addr,
    output logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         result_data,
    output logic                  result_err
);
    obr_state_e    st_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          we_q;
    logic          err_q;
    obr_result_e   res;

    assign res = obr_resolve(bus_berr_n, bus_dtack_n, expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= cpu_addr;
                        wdata_q <= cpu_wdata;
                        we_q    <= cpu_we;
                        err_q   <= 1'b0;
                        st_q    <= ST_REQUEST;
                    end
                end
                ST_REQUEST:    st_q <= ST_WAIT_GRANT;
                ST_WAIT_GRANT: if (!bus_bg_in_n) st_q <= ST_ADDRESS;
                ST_ADDRESS:    st_q <= ST_WAIT_ACK;
                ST_WAIT_ACK: begin
                    if (res == RES_OK) begin
                        rdata_q <= bus_rdata;
                        st_q    <= ST_RELEASE;
                    end else if (res == RES_FAIL) begin
                        rdata_q <= '0;
                        err_q   <= 1'b1;
                        st_q    <= ST_RELEASE;
                    end
                end
                ST_RELEASE:    st_q <= ST_IDLE;
                default:       st_q <= ST_IDLE;
            endcase
        end
    end

    logic req_on;
    logic drive;

    assign req_on = (st_q == ST_REQUEST) || (st_q == ST_WAIT_GRANT);
    assign drive  = (st_q == ST_ADDRESS) || (st_q == ST_WAIT_ACK);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        if (g == REQ_LEVEL) begin : g_used
            assign bus_br_n[g] = !req_on;
        end else begin : g_idle
            assign bus_br_n[g] = 1'b1;
        end
    end

    assign bus_bbsy_n  = !drive;
    assign bus_as_n    = (st_q != ST_WAIT_ACK);
    assign bus_write_n = drive ? !we_q : 1'b1;
    assign bus_addr    = drive ? addr_q : '0;
    assign bus_wdata   = (drive && we_q) ? wdata_q : '0;
    assign state       = st_q;
    assign result_data = rdata_q;
    assign result_err  = err_q;
endmodule

// File: rtl/obr_requester.sv
module obr_requester
    import obr_pkg::*;
#(
    parameter int unsigned   AW        = 24,
    parameter int unsigned   DW        = 16,
    parameter logic [AW-1:0] WIN_BASE  = 'h800000,
    parameter logic [AW-1:0] WIN_LAST  = 'hBFFFFF,
    parameter int unsigned   REQ_LEVEL = 3,
    parameter int unsigned   TIMEOUT   = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic          cpu_done,
    output logic          cpu_err,
    output logic [DW-1:0] cpu_rdata,
    output logic          loc_en,
    output logic          loc_we,
    output logic [AW-1:0] loc_addr,
    output logic [DW-1:0] loc_wdata,
    input  logic [DW-1:0] loc_rdata,
    output logic [3:0]    bus_br_n,
    input  logic          bus_bg_in_n,
    output logic          bus_bg_out_n,
    output logic          bus_bbsy_n,
    output logic          bus_as_n,
    output logic          bus_write_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_dtack_n,
    input  logic          bus_berr_n
);
    obr_state_e    state;
    logic          remote;
    logic          accept;
    logic          expired;
    logic          loc_done_q;
    logic [DW-1:0] result_data;
    logic          result_err;
    logic          finishing;

    obr_decode #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) u_decode (
        .addr   (cpu_addr),
        .remote (remote)
    );

    obr_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT_ACK),
        .expired (expired)
    );

    obr_seq #(.AW(AW), .DW(DW), .REQ_LEVEL(REQ_LEVEL)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && remote),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .bus_bg_in_n (bus_bg_in_n),
        .bus_rdata   (bus_rdata),
        .bus_dtack_n (bus_dtack_n),
        .bus_berr_n  (bus_berr_n),
        .expired     (expired),
        .state       (state),
        .bus_br_n    (bus_br_n),
        .bus_bbsy_n  (bus_bbsy_n),
        .bus_as_n    (bus_as_n),
        .bus_write_n (bus_write_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .result_data (result_data),
        .result_err  (result_err)
    );

    assign cpu_ready = (state == ST_IDLE);
    assign accept    = cpu_req && cpu_ready;
    assign finishing = (state == ST_RELEASE);

    assign loc_en    = accept && !remote;
    assign loc_we    = cpu_we;
    assign loc_addr  = cpu_addr;
    assign loc_wdata = cpu_wdata;

    always_ff @(posedge clk) begin
        if (rst) loc_done_q <= 1'b0;
        else     loc_done_q <= loc_en;
    end

    assign cpu_done  = loc_done_q || finishing;
    assign cpu_err   = finishing && result_err;
    assign cpu_rdata = loc_done_q ? loc_rdata : (finishing ? result_data : '0);

    assign bus_bg_out_n = (state == ST_IDLE) ? bus_bg_in_n : 1'b1;
endmodule

// File: rtl/obr_checker.sv
module obr_checker #(
    parameter int unsigned AW      = 24,
    parameter int unsigned TIMEOUT = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_ready,
    input logic          cpu_done,
    input logic          cpu_err,
    input logic [3:0]    bus_br_n,
    input logic          bus_bg_out_n,
    input logic          bus_bbsy_n,
    input logic          bus_as_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_dtack_n,
    input logic          bus_berr_n
);
    localparam int unsigned CW = $clog2(TIMEOUT + 2);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || bus_as_n) low_cnt <= '0;
        else                 low_cnt <= low_cnt + 1'b1;
    end

    AST_ONE_LEVEL:      assert property (@(posedge clk) disable iff (rst)
        $countones(~bus_br_n) <= 1);                                   // R3
    AST_BBSY_WITH_AS:   assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |-> !bus_bbsy_n);                                    // R4
    AST_ADDR_SETTLED:   assert property (@(posedge clk) disable iff (rst)
        $fell(bus_as_n) |-> ($stable(bus_addr) && !bus_bbsy_n));       // R5
    AST_ACK_ENDS:       assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && !bus_dtack_n) |=> (bus_as_n && cpu_done));       // R6
    AST_ERR_ENDS:       assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && !bus_berr_n) |=> (cpu_done && cpu_err));         // R7
    AST_ERR_WITH_DONE:  assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> cpu_done);                                         // R7
    AST_STROBE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        !bus_as_n |-> (low_cnt < CW'(TIMEOUT)));                       // R8
    AST_CHAIN_BLOCKED:  assert property (@(posedge clk) disable iff (rst)
        ($countones(~bus_br_n) != 0) |-> bus_bg_out_n);                // R9
    AST_READY_QUIET:    assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (bus_as_n && bus_bbsy_n && (&bus_br_n)));        // R10
endmodule

bind obr_requester obr_checker #(.AW(AW), .TIMEOUT(TIMEOUT)) u_obr_checker (
    .clk          (clk),
    .rst          (rst),
    .cpu_ready    (cpu_ready),
    .cpu_done     (cpu_done),
    .cpu_err      (cpu_err),
    .bus_br_n     (bus_br_n),
    .bus_bg_out_n (bus_bg_out_n),
    .bus_bbsy_n   (bus_bbsy_n),
    .bus_as_n     (bus_as_n),
    .bus_addr     (bus_addr),
    .bus_dtack_n  (bus_dtack_n),
    .bus_berr_n   (bus_berr_n)
);

// File: tb/obr_requester_test.sv
`timescale 1ns/1ps
module obr_requester_test;
    localparam int AW  = 24;
    localparam int DW  = 16;
    localparam int LVL = 3;
    localparam int TO  = 16;
    localparam logic [AW-1:0] WB = 24'h800000;
    localparam logic [AW-1:0] WL = 24'hBFFFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_done, cpu_err;
    logic [DW-1:0] cpu_rdata;
    logic loc_en, loc_we;
    logic [AW-1:0] loc_addr;
    logic [DW-1:0] loc_wdata;
    logic [DW-1:0] loc_rdata = '0;
    logic [3:0] bus_br_n;
    logic bus_bg_in_n = 1'b1;
    logic bus_bg_out_n, bus_bbsy_n, bus_as_n, bus_write_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_dtack_n = 1'b1, bus_berr_n = 1'b1;

    always #2 clk = ~clk;

    obr_requester #(.AW(AW), .DW(DW), .WIN_BASE(WB), .WIN_LAST(WL),
                    .REQ_LEVEL(LVL), .TIMEOUT(TO)) uut (.*);

    int checks = 0, fails = 0, cycles = 0;

    // environment settings
    int gnt_delay = 0, resp_kind = 0, resp_delay = 0;
    logic foreign_bg_n = 1'b1;
    int gcnt = 0, acnt = 0;
    logic loc_pend = 1'b0;
    logic [AW-1:0] loc_addr_q = '0;

    // reference model
    int ph = 0, wcnt = 0, why = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0, m_rd = '0;
    logic m_we = 1'b0, m_err = 1'b0, m_ldone = 1'b0;

    function automatic logic in_win(input logic [AW-1:0] a);
        return (a >= WB) && (a <= WL);
    endfunction

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction

    task automatic chk(input string tag, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s got %h expected %h at cycle %0d", tag, nm, act, exp, cycles);
        end
    endtask

    task automatic compare_and_step();
        logic drv, e_loc, e_done;
        logic [3:0] e_br;
        string dtag;
        drv   = (ph == 3) || (ph == 4);
        e_loc = cpu_req && (ph == 0) && !in_win(cpu_addr);
        e_br  = (ph == 1 || ph == 2) ? ~(4'b1 << LVL) : 4'hF;
        e_done = m_ldone || (ph == 5);
        dtag  = m_ldone ? "R2" : (why == 2 ? "R8" : (why == 1 ? "R7" : "R6"));
        chk("R1",  "loc_en",   loc_en, e_loc);
        if (e_loc) begin
            chk("R1", "loc_addr", loc_addr, cpu_addr);
            chk("R1", "loc_we",   loc_we,   cpu_we);
            chk("R1", "loc_wdata", loc_wdata, cpu_wdata);
        end
        chk("R3",  "bus_br_n", bus_br_n, e_br);
        chk("R4",  "bus_bbsy_n", bus_bbsy_n, !drv);
        chk("R5",  "bus_as_n", bus_as_n, ph != 4);
        chk("R5",  "bus_addr", bus_addr, drv ? m_addr : '0);
        chk("R5",  "bus_write_n", bus_write_n, drv ? !m_we : 1'b1);
        chk("R5",  "bus_wdata", bus_wdata, (drv && m_we) ? m_wd : '0);
        chk("R9",  "bus_bg_out_n", bus_bg_out_n, (ph == 0) ? bus_bg_in_n : 1'b1);
        chk("R10", "cpu_ready", cpu_ready, ph == 0);
        chk(dtag,  "cpu_done", cpu_done, e_done);
        chk(dtag,  "cpu_err",  cpu_err, (ph == 5) && m_err);
        chk(dtag,  "cpu_rdata", cpu_rdata, m_ldone ? loc_rdata : ((ph == 5) ? m_rd : '0));
        // advance the model to the next cycle
        m_ldone = e_loc;
        loc_pend = e_loc;
        loc_addr_q = cpu_addr;
        case (ph)
            0: if (cpu_req && in_win(cpu_addr)) begin
                   m_addr = cpu_addr; m_we = cpu_we; m_wd = cpu_wdata;
                   m_err = 1'b0; why = 0; ph = 1;
               end
            1: ph = 2;
            2: if (!bus_bg_in_n) ph = 3;
            3: begin ph = 4; wcnt = 0; end
            4: begin
                   if (!bus_berr_n)       begin m_err = 1'b1; m_rd = '0; why = 1; ph = 5; end
                   else if (!bus_dtack_n) begin m_rd = bus_rdata; why = 0; ph = 5; end
                   else if (wcnt == TO-1) begin m_err = 1'b1; m_rd = '0; why = 2; ph = 5; end
                   else wcnt++;
               end
            5: ph = 0;
            default: ph = 0;
        endcase
    endtask

    // environment: local memory, arbiter, remote slave; then compare
    always @(negedge clk) begin
        logic br_low, active;
        if (loc_pend) loc_rdata = mem_val(loc_addr_q);
        br_low = (bus_br_n[LVL] == 1'b0);
        if (br_low) gcnt++; else gcnt = 0;
        bus_bg_in_n = br_low ? !(gcnt > gnt_delay) : foreign_bg_n;
        if (!bus_as_n) acnt++; else acnt = 0;
        active = !bus_as_n && (acnt > resp_delay);
        bus_dtack_n = !(active && (resp_kind == 0 || resp_kind == 3));
        bus_berr_n  = !(active && (resp_kind == 1 || resp_kind == 3));
        #1;
        if (rst) begin
            ph = 0; m_ldone = 1'b0; loc_pend = 1'b0; m_err = 1'b0;
            m_addr = '0; m_wd = '0; m_rd = '0; m_we = 1'b0;
        end else begin
            compare_and_step();
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            summary();
        end
    end

    task automatic op(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                      input int gd, input int kind, input int dly,
                      input logic [DW-1:0] rd, input bit stray);
        int n;
        gnt_delay = gd; resp_kind = kind; resp_delay = dly; bus_rdata = rd;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 0;
        while (!cpu_done && n < 200) begin
            // R10: stray local request while busy must be dropped
            if (stray && (n == 1 || n == 4)) begin
                cpu_req = 1'b1; cpu_addr = 24'h000040; cpu_we = 1'b0;
            end else cpu_req = 1'b0;
            @(negedge clk);
            n++;
        end
        // R10: stray request in the completion cycle of a remote access
        cpu_req = stray && (n > 0);
        cpu_addr = 24'h000044;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk("R11", "cpu_ready", cpu_ready, 1'b1);
        chk("R11", "bus_br_n", bus_br_n, 4'hF);
        chk("R11", "bus_as_n/bbsy_n/write_n", {bus_as_n, bus_bbsy_n, bus_write_n}, 3'b111);
        chk("R11", "bus_addr", bus_addr, '0);
        chk("R11", "bus_wdata", bus_wdata, '0);
        chk("R11", "cpu_done", cpu_done, 1'b0);

        // R1/R2: local accesses, including window edges
        op(24'h000100, 1'b0, '0, 0, 0, 0, '0, 0);
        op(WB - 1, 1'b1, 16'hBEEF, 0, 0, 0, '0, 0);
        op(WL + 1, 1'b0, '0, 0, 0, 0, '0, 0);
        // R3..R6: remote read at base with grant delay, remote write at top
        op(WB, 1'b0, '0, 3, 0, 1, 16'h1234, 1);
        op(WL, 1'b1, 16'hA55A, 0, 0, 0, 16'h0F0F, 0);
        // R7: bus error, then error and acknowledge together
        op(24'h900000, 1'b0, '0, 1, 1, 2, 16'h7777, 1);
        op(24'h900004, 1'b1, 16'h1111, 0, 3, 0, 16'h8888, 0);
        // R8: silence, acknowledge in last allowed cycle, one too late
        op(24'hA00000, 1'b0, '0, 0, 2, 0, 16'h2222, 0);
        op(24'hA00002, 1'b0, '0, 2, 0, TO-1, 16'h3333, 0);
        op(24'hA00004, 1'b0, '0, 0, 0, TO, 16'h4444, 0);
        // R9: foreign grant while idle is passed on, while requesting it is blocked
        foreign_bg_n = 1'b0;
        repeat (3) @(negedge clk);
        op(24'hB00000, 1'b0, '0, 4, 0, 0, 16'h5555, 0);
        foreign_bg_n = 1'b1;
        repeat (2) @(negedge clk);
        // back-to-back local accesses
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            cpu_req = 1'b1; cpu_addr = 24'(i * 8 + 16); cpu_we = 1'b0;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        repeat (4) @(negedge clk);
        summary();
    end
endmodule